// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial characters from a one-entry holding register that sits in front of a frame shifter. Software writes a character into the holding register. On a bit-rate tick, the character moves into the shifter, either when the shifter is idle or on the tick that closes the last stop bit of the frame in progress. Because of this, consecutive characters leave the line with no idle gap. A bit-rate tick input (one clock wide, once per bit time) sets the pace of every bit, so the block contains no baud-rate generator.

The control word selects the following: transmit enable, character length (5 to 9 data bits), whether parity is sent, the parity sense, and one or two stop bits. It also holds the ninth data bit, staged for 9-bit characters, and one interrupt enable for each of the two status flags. The buffer-empty flag shows that the holding register can take another character. The transmit-complete flag shows that the line has drained completely. Software clears either flag by writing 0 to its status bit. The complete flag can also be cleared by an interrupt acknowledge.

Top module: `sertx_top`

## Requirements
- R1: After a synchronous reset: the line is high, the buffer-empty flag is 1, the complete flag is 0, both interrupt outputs are 0 and all control bits are 0.
- R2: Frame layout on the line: a start bit of 0, then the data bits LSB first, then the optional parity bit, then the stop bits of 1. Every bit lasts from one bit tick to the next, and an idle line is high.
- R3: Control word bits [3:1] give the character length. Codes 0 to 3 mean 5 to 8 data bits and codes 4 to 7 mean 9 data bits. The ninth data bit is taken from control bit [7] at the moment the data register is written.
- R4: Control bit [4] enables parity and control bit [5] chooses the parity sense (0 even, 1 odd). Parity covers every data bit of the configured length and is sent after the last data bit, before the first stop bit.
- R5: Control bit [6] selects two stop bits when 1 and one stop bit when 0.
- R6: The holding register moves into the shifter only on a bit tick, and only when the shifter is idle or that tick ends the last stop bit. In the second case the next start bit follows with no idle bit time.
- R7: A frame uses the length, parity and stop settings that are in force when it is loaded. Control writes made during the frame do not change it.
- R8: The buffer-empty flag (status bit [0]) drops to 0 in the cycle after a data write and returns to 1 after a handoff. A second write before the handoff replaces the pending character.
- R9: A status write with bit [0] = 0 clears the buffer-empty flag, and a 1 in that bit has no effect. A handoff in the same cycle wins over the clear, and a data write wins over both.
- R10: The complete flag (status bit [1]) is set when a frame ends with the holding register empty. A data write in the same cycle as that final tick still lets the flag set.
- R11: The complete flag is cleared by the acknowledge input or by a status write with bit [1] = 0. Writing 1 has no effect, and setting wins over clearing in the same cycle.
- R12: Each interrupt output is high exactly while its flag is 1, its enable is 1 (control bit [8] for empty, control bit [9] for complete) and the global enable input is 1.
- R13: While control bit [0] (enable) is 0, no handoff takes place and the idle line stays high. Clearing the bit during a frame lets that frame finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 10 | Control word |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Character low byte |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 2 | Status write value: [0] empty flag, [1] complete flag |
| tc_ack | input | 1 | Complete interrupt acknowledge |
| gie | input | 1 | Global interrupt enable |
| txd | output | 1 | Serial line |
| empty_flag | output | 1 | Holding register empty flag |
| done_flag | output | 1 | Transmit complete flag |
| empty_irq | output | 1 | Empty interrupt |
| done_irq | output | 1 | Complete interrupt |

## Verification
The timing-sensitive cases are the ones where the tick that ends a frame's last stop bit lands in the same cycle as a software action: a data write, an acknowledge, or a status clear. A handoff that lands in the same cycle as a software clear of the empty flag is the other such case. The bench uses its own model to find the cycle just before that tick and applies the action in that cycle. Every clock it compares the line, both flags and both interrupts with the model. This shows whether the set-over-clear and write-over-handoff priorities hold, and whether the following frame starts with no gap.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // low byte width of a character
    localparam int unsigned DW      = 8;
    // widest character (ninth bit on top)
    localparam int unsigned CW      = DW + 1;
    // shortest character length
    localparam int unsigned MIN_LEN = 5;
    // start + widest character + parity + two stops
    localparam int unsigned FW      = CW + 4;
    localparam int unsigned CNT_W   = $clog2(FW + 1);
    // status flags with interrupt lines
    localparam int unsigned N_IRQ   = 2;
    localparam int unsigned IRQ_EMPTY = 0;
    localparam int unsigned IRQ_DONE  = 1;

    typedef struct packed {
        logic       ie_done;    // [9]
        logic       ie_empty;   // [8]
        logic       bit9;       // [7]
        logic       two_stop;   // [6]
        logic       par_odd;    // [5]
        logic       par_en;     // [4]
        logic [2:0] size;       // [3:1]
        logic       tx_en;      // [0]
    } tx_cfg_t;

    localparam int unsigned CFG_W = $bits(tx_cfg_t);

    typedef struct packed {
        logic [FW-1:0]    bits;   // LSB goes out first
        logic [CNT_W-1:0] len;    // bit times in frame
    } frame_t;

    function automatic logic [CNT_W-1:0] char_len(input logic [2:0] code);
        if (code[2]) begin
            return CNT_W'(CW);
        end
        return CNT_W'(MIN_LEN) + CNT_W'(code[1:0]);
    endfunction

    function automatic frame_t build_frame(input logic [CW-1:0] word,
                                           input tx_cfg_t       cfg);
        frame_t           f;
        logic [CNT_W-1:0] n;
        logic             par;
        int               pidx;
        n      = char_len(cfg.size);
        f.bits = '1;
        f.bits[0] = 1'b0;
        par    = cfg.par_odd;
        for (int i = 0; i < CW; i++) begin
            if (i < int'(n)) begin
                f.bits[1 + i] = word[i];
                par           = par ^ word[i];
            end
        end
        pidx = 1 + int'(n);
        if (cfg.par_en) begin
            f.bits[pidx] = par;
        end
        f.len = n + CNT_W'(2) + CNT_W'(cfg.par_en) + CNT_W'(cfg.two_stop);
        return f;
    endfunction

endpackage

// File: rtl/sertx_cfg_reg.sv
module sertx_cfg_reg
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output tx_cfg_t          cfg_o
);

    tx_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= tx_cfg_t'(wdata);
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          dat_we,
    input  logic [DW-1:0] dat_wdata,
    input  logic          bit9_i,
    input  logic          load_i,
    input  logic          sw_clr_i,
    output logic          full_o,
    output logic [CW-1:0] word_o,
    output logic          empty_o
);

    logic          full_q;
    logic          empty_q;
    logic [CW-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q  <= 1'b0;
            empty_q <= 1'b1;
            word_q  <= '0;
        end else if (dat_we) begin
            word_q  <= {bit9_i, dat_wdata};
            full_q  <= 1'b1;
            empty_q <= 1'b0;
        end else if (load_i) begin
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else if (sw_clr_i) begin
            empty_q <= 1'b0;
        end
    end

    assign full_o  = full_q;
    assign word_o  = word_q;
    assign empty_o = empty_q;

    // R8: a data write leaves a pending character and a low flag
    a_r8_write_pends: assert property (@(posedge clk) disable iff (rst)
        dat_we |=> (full_q && !empty_q));

    // R6: a handoff without a new write drains the holding register
    a_r6_handoff_drains: assert property (@(posedge clk) disable iff (rst)
        (load_i && !dat_we) |=> (empty_q && !full_q));

    // R9: software can never raise the empty flag
    a_r9_no_sw_set: assert property (@(posedge clk) disable iff (rst)
        (!empty_q && !load_i && !dat_we) |=> !empty_q);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_tick,
    input  tx_cfg_t       cfg_i,
    input  logic          full_i,
    input  logic [CW-1:0] word_i,
    output logic          load_o,
    output logic          frame_end_o,
    output logic          txd_o
);

    logic [FW-1:0]    sr_q;
    logic [CNT_W-1:0] left_q;
    logic             busy_q;
    logic             last_bit;
    frame_t           next_frame;

    assign next_frame  = build_frame(word_i, cfg_i);
    assign last_bit    = busy_q && (left_q == CNT_W'(1));
    assign load_o      = bit_tick && (!busy_q || last_bit) && full_i && cfg_i.tx_en;
    assign frame_end_o = bit_tick && last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '1;
            left_q <= '0;
            busy_q <= 1'b0;
        end else if (load_o) begin
            sr_q   <= next_frame.bits;
            left_q <= next_frame.len;
            busy_q <= 1'b1;
        end else if (bit_tick && busy_q) begin
            sr_q   <= {1'b1, sr_q[FW-1:1]};
            left_q <= left_q - CNT_W'(1);
            if (last_bit) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign txd_o = busy_q ? sr_q[0] : 1'b1;

    // R2: the line only moves after a tick
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(txd_o));

    // R2: every loaded frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !txd_o);

    // R13: an idle shifter stays idle while disabled
    a_r13_stay_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !cfg_i.tx_en) |=> !busy_q);

endmodule

// File: rtl/sertx_status.sv
module sertx_status
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_end_i,
    input  logic             full_i,
    input  logic             ack_i,
    input  logic             sw_clr_i,
    input  logic             empty_i,
    input  logic [N_IRQ-1:0] ie_i,
    input  logic             gie_i,
    output logic             done_o,
    output logic [N_IRQ-1:0] irq_o
);

    logic             done_q;
    logic             done_set;
    logic [N_IRQ-1:0] src;

    assign done_set = frame_end_i && !full_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else if (done_set) begin
            done_q <= 1'b1;
        end else if (ack_i || sw_clr_i) begin
            done_q <= 1'b0;
        end
    end

    assign done_o = done_q;

    always_comb begin
        src            = '0;
        src[IRQ_EMPTY] = empty_i;
        src[IRQ_DONE]  = done_q;
    end

    for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
        assign irq_o[g] = src[g] && ie_i[g] && gie_i;
    end

    // R10: the flag only rises after a frame ends with nothing pending
    a_r10_set_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(frame_end_i && !full_i));

    // R11: acknowledge clears unless a set coincides
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !(frame_end_i && !full_i)) |=> !done_q);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             dat_we,
    input  logic [DW-1:0]    dat_wdata,
    input  logic             sts_we,
    input  logic [1:0]       sts_wdata,
    input  logic             tc_ack,
    input  logic             gie,
    output logic             txd,
    output logic             empty_flag,
    output logic             done_flag,
    output logic             empty_irq,
    output logic             done_irq
);

    tx_cfg_t          cfg;
    logic             full;
    logic [CW-1:0]    word;
    logic             load;
    logic             frame_end;
    logic             empty_clr;
    logic             done_clr;
    logic [N_IRQ-1:0] ie;
    logic [N_IRQ-1:0] irq;

    assign empty_clr = sts_we && !sts_wdata[0];
    assign done_clr  = sts_we && !sts_wdata[1];

    always_comb begin
        ie            = '0;
        ie[IRQ_EMPTY] = cfg.ie_empty;
        ie[IRQ_DONE]  = cfg.ie_done;
    end

    sertx_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_o (cfg)
    );

    sertx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .bit9_i    (cfg.bit9),
        .load_i    (load),
        .sw_clr_i  (empty_clr),
        .full_o    (full),
        .word_o    (word),
        .empty_o   (empty_flag)
    );

    sertx_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .bit_tick    (bit_tick),
        .cfg_i       (cfg),
        .full_i      (full),
        .word_i      (word),
        .load_o      (load),
        .frame_end_o (frame_end),
        .txd_o       (txd)
    );

    sertx_status u_status (
        .clk         (clk),
        .rst         (rst),
        .frame_end_i (frame_end),
        .full_i      (full),
        .ack_i       (tc_ack),
        .sw_clr_i    (done_clr),
        .empty_i     (empty_flag),
        .ie_i        (ie),
        .gie_i       (gie),
        .done_o      (done_flag),
        .irq_o       (irq)
    );

    assign empty_irq = irq[IRQ_EMPTY];
    assign done_irq  = irq[IRQ_DONE];

endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;

    localparam int TDIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [9:0] cfg_wdata = '0;
    logic       dat_we = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic       sts_we = 1'b0;
    logic [1:0] sts_wdata = '0;
    logic       tc_ack = 1'b0;
    logic       gie = 1'b0;
    logic       txd, empty_flag, done_flag, empty_irq, done_irq;

    always #10 clk = ~clk;

    sertx_top u0 (
        .clk(clk), .rst(rst), .bit_tick(bit_tick),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata),
        .tc_ack(tc_ack), .gie(gie),
        .txd(txd), .empty_flag(empty_flag), .done_flag(done_flag),
        .empty_irq(empty_irq), .done_irq(done_irq)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    tcnt  = 0;
    string phase = "R1 reset";
    logic [9:0] cv = '0;

    // reference model state
    bit        m_q[$];
    bit        m_busy = 0;
    bit        m_full = 0;
    bit        m_emp  = 1;
    bit        m_done = 0;
    bit [8:0]  m_buf  = '0;
    bit [9:0]  m_cfg  = '0;

    always @(posedge clk) begin
        bit fend, ld, par;
        int n;
        if (rst) begin
            m_q.delete(); m_busy = 0; m_full = 0; m_emp = 1; m_done = 0;
            m_buf = '0; m_cfg = '0;
        end else begin
            fend = bit_tick && m_busy && (m_q.size() == 1);
            ld   = bit_tick && (!m_busy || fend) && m_full && m_cfg[0];
            if (bit_tick && m_busy) void'(m_q.pop_front());
            if (fend) m_busy = 0;
            if (ld) begin
                n = (m_cfg[3:1] >= 4) ? 9 : 5 + int'(m_cfg[3:1]);
                par = m_cfg[5];
                m_q.delete();
                m_q.push_back(1'b0);
                for (int i = 0; i < n; i++) begin
                    m_q.push_back(m_buf[i]);
                    par = par ^ m_buf[i];
                end
                if (m_cfg[4]) m_q.push_back(par);
                m_q.push_back(1'b1);
                if (m_cfg[6]) m_q.push_back(1'b1);
                m_busy = 1;
            end
            if (fend && !m_full) m_done = 1;
            else if (tc_ack || (sts_we && !sts_wdata[1])) m_done = 0;
            if (dat_we) begin
                m_buf = {m_cfg[7], dat_wdata}; m_full = 1; m_emp = 0;
            end else if (ld) begin
                m_full = 0; m_emp = 1;
            end else if (sts_we && !sts_wdata[0]) begin
                m_emp = 0;
            end
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s / %s: actual %0h expected %0h at %0t", phase, tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R2 line", 16'(txd), 16'(m_busy ? m_q[0] : 1'b1));
        chk("R8 empty flag", 16'(empty_flag), 16'(m_emp));
        chk("R10 done flag", 16'(done_flag), 16'(m_done));
        chk("R12 empty irq", 16'(empty_irq), 16'(m_emp & m_cfg[8] & gie));
        chk("R12 done irq", 16'(done_irq), 16'(m_done & m_cfg[9] & gie));
    endtask

    task automatic step();
        tcnt++;
        bit_tick = (tcnt % TDIV == 0);
        @(posedge clk);
        @(negedge clk);
        compare();
        dat_we = 0; cfg_we = 0; sts_we = 0; tc_ack = 0;
    endtask

    task automatic steps(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic put_cfg();
        cfg_we = 1; cfg_wdata = cv; step();
    endtask

    task automatic put_data(input logic [7:0] d);
        dat_we = 1; dat_wdata = d; step();
    endtask

    task automatic drain();
        while (m_busy || m_full) step();
        steps(3);
    endtask

    function automatic bit final_next();
        return ((tcnt + 1) % TDIV == 0) && m_busy && (m_q.size() == 1);
    endfunction

    task automatic to_final();
        while (!final_next()) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired in phase %s", phase);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        steps(3);
        rst = 0;
        step();
        phase = "R1 reset";
        chk("R1 txd", 16'(txd), 16'h1);
        chk("R1 empty", 16'(empty_flag), 16'h1);
        chk("R1 done", 16'(done_flag), 16'h0);
        chk("R1 irqs", 16'({empty_irq, done_irq}), 16'h0);

        phase = "R2 8-bit no parity";
        cv = 10'b00_0_0_0_0_011_1; put_cfg();
        put_data(8'hA5);
        drain();
        chk("R10 done after frame", 16'(done_flag), 16'h1);

        phase = "R11 ack and writes";
        tc_ack = 1; step();
        chk("R11 ack clears", 16'(done_flag), 16'h0);
        put_data(8'h3C); drain();
        sts_we = 1; sts_wdata = 2'b11; step();
        chk("R11 write 1 ignored", 16'(done_flag), 16'h1);
        sts_we = 1; sts_wdata = 2'b01; step();
        chk("R11 write 0 clears", 16'(done_flag), 16'h0);
        chk("R9 bit0=1 keeps empty", 16'(empty_flag), 16'h1);

        phase = "R6 back-to-back";
        put_data(8'h0F); steps(2);
        put_data(8'hF0);
        while (!m_emp) step();
        put_data(8'h81);
        drain();

        phase = "R8 overwrite while disabled";
        cv[0] = 0; put_cfg();
        put_data(8'h11); put_data(8'h22);
        chk("R8 pending", 16'(empty_flag), 16'h0);
        phase = "R13 disabled holds line";
        steps(20);
        chk("R13 line idle", 16'(txd), 16'h1);
        cv[0] = 1; put_cfg(); drain();

        phase = "R3 character lengths";
        for (int c = 0; c < 8; c++) begin
            cv[3:1] = 3'(c); put_cfg();
            put_data(8'(8'h5A ^ (c * 37)));
            drain();
        end
        cv[0] = 0; cv[7] = 1; put_cfg();
        put_data(8'hC6);
        cv[0] = 1; cv[7] = 0; put_cfg();
        drain();
        put_data(8'h39); drain();

        phase = "R4 parity";
        for (int c = 0; c < 8; c++) begin
            cv[3:1] = 3'(c); cv[4] = 1; cv[5] = c[0]; cv[7] = c[1]; put_cfg();
            put_data(8'(8'h96 + c * 19));
            drain();
        end

        phase = "R5 two stop bits";
        cv[3:1] = 3'd3; cv[6] = 1; put_cfg();
        put_data(8'hE7); put_data(8'h18); drain();
        cv[4] = 0; put_cfg();
        put_data(8'h00); drain();

        phase = "R7 load-time settings";
        cv = 10'b00_0_0_0_0_011_1; put_cfg();
        put_data(8'hB2); steps(9);
        cv = 10'b00_0_1_1_1_000_1; put_cfg();
        put_data(8'h4D);
        drain();

        phase = "R9 empty clear";
        sts_we = 1; sts_wdata = 2'b10; step();
        chk("R9 write 0 clears", 16'(empty_flag), 16'h0);
        sts_we = 1; sts_wdata = 2'b11; step();
        chk("R9 write 1 ignored", 16'(empty_flag), 16'h0);
        put_data(8'h66);
        while ((tcnt + 1) % TDIV != 0) step();
        sts_we = 1; sts_wdata = 2'b10; step();
        chk("R9 handoff beats clear", 16'(empty_flag), 16'h1);
        drain();

        phase = "R10 write on final tick";
        tc_ack = 1; step();
        put_data(8'hA9);
        to_final();
        dat_we = 1; dat_wdata = 8'h5E; step();
        chk("R10 done sets", 16'(done_flag), 16'h1);
        chk("R8 write pending", 16'(empty_flag), 16'h0);
        drain();

        phase = "R11 set beats ack";
        tc_ack = 1; step();
        put_data(8'h72);
        to_final();
        tc_ack = 1; step();
        chk("R11 set wins", 16'(done_flag), 16'h1);
        sts_we = 1; sts_wdata = 2'b01; step();

        phase = "R12 interrupts";
        cv[8] = 1; cv[9] = 1; put_cfg();
        gie = 0; step();
        chk("R12 gie off", 16'({empty_irq, done_irq}), 16'h0);
        gie = 1; step();
        chk("R12 empty irq on", 16'(empty_irq), 16'h1);
        put_data(8'h21); drain();
        chk("R12 done irq on", 16'(done_irq), 16'h1);
        cv[9] = 0; put_cfg();
        chk("R12 done irq masked", 16'(done_irq), 16'h0);
        tc_ack = 1; step();

        phase = "R13 disable mid-frame";
        put_data(8'hD4); steps(6);
        cv[0] = 0; put_cfg();
        put_data(8'h4B);
        steps(80);
        chk("R13 no handoff", 16'(empty_flag), 16'h0);
        chk("R13 line idle", 16'(txd), 16'h1);
        chk("R10 not set with pending", 16'(done_flag), 16'h0);
        cv[0] = 1; put_cfg(); drain();
        chk("R13 resumes", 16'(done_flag), 16'h1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule